// File: doc/BRIEF.md
# Occupancy-Gated Burst Command Scheduler

This block drives a read-only master port and a write-only master port that share one channel data FIFO. A source context (start address and byte count) is split into read commands, and the returned beats are written into the FIFO. A destination context is split into write commands, and the beats are drained from the FIFO to feed them. Each command is at most one 128-byte burst and never crosses a 128-byte aligned address. The last command of a context carries only what is left.

The two sides run independently and are linked only through FIFO occupancy. A read command goes out only when the FIFO can hold every beat it will return. Space is reserved at issue, not on return. A write command goes out only when enough unclaimed data already sits in the FIFO. This lets the source side start a new context while the destination side is still draining the previous one.

The data path is 128 bits (16 bytes per beat). Addresses and byte counts are taken in whole beats.

Top module: `burst_sched`

## Requirements
- R1: Each read command's byte length is 16 × min(beats left in the source context, beats up to the next 128-byte aligned address). Its address is the context start plus the bytes already commanded.
- R2: Write commands are split from the destination context by the same rule as R1.
- R3: `rd_cmd_valid` is high exactly when a source context is active, beats remain to be commanded, and FIFO occupancy + beats commanded but not yet returned + this command's beats ≤ FIFO depth (16 beats by default).
- R4: `wr_cmd_valid` is high exactly when a destination context is active, beats remain to be commanded, and FIFO occupancy − beats already committed to accepted write commands ≥ this command's beats.
- R5: `wr_beat_valid` is high exactly while beats committed to accepted write commands remain unsent. The beats leave in the order the read-return beats arrived.
- R6: `src_ready` is low while a source context is active. `src_done` is a one-cycle pulse in the cycle after the final read-return beat of that context is accepted.
- R7: `dst_ready` is low while a destination context is active. `dst_done` is a one-cycle pulse in the cycle after the final write beat of that context is accepted.
- R8: A new source context is accepted while a destination context is still active.
- R9: A context with a byte count below 16 issues no command, and its done strobe pulses in the cycle after it is accepted.
- R10: The low 4 bits of context addresses and byte counts are ignored. Command addresses are always multiples of 16.
- R11: A command whose valid is high while its ready is low stays valid in the next cycle with unchanged address and length.
- R12: After reset, no command or beat is valid, no done strobe is high, and both context inputs are ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_valid | input | 1 | Source context offered |
| src_ready | output | 1 | Source side idle, context taken on valid |
| src_addr | input | 32 | Source start byte address |
| src_bytes | input | 16 | Source byte count |
| src_done | output | 1 | Source context fully returned |
| dst_valid | input | 1 | Destination context offered |
| dst_ready | output | 1 | Destination side idle |
| dst_addr | input | 32 | Destination start byte address |
| dst_bytes | input | 16 | Destination byte count |
| dst_done | output | 1 | Destination context fully written |
| rd_cmd_valid | output | 1 | Read command valid |
| rd_cmd_ready | input | 1 | Read command accepted |
| rd_cmd_addr | output | 32 | Read command byte address |
| rd_cmd_bytes | output | 8 | Read command byte length |
| rd_ret_valid | input | 1 | Read-return beat valid |
| rd_ret_data | input | 128 | Read-return beat |
| wr_cmd_valid | output | 1 | Write command valid |
| wr_cmd_ready | input | 1 | Write command accepted |
| wr_cmd_addr | output | 32 | Write command byte address |
| wr_cmd_bytes | output | 8 | Write command byte length |
| wr_beat_valid | output | 1 | Write beat valid |
| wr_beat_ready | input | 1 | Write beat accepted |
| wr_beat_data | output | 128 | Write beat from the FIFO |

## Verification
A FIFO push from a read return and a FIFO pop from a write beat can fall in the same cycle. So can the reservation made by a read command and the release of space by a pop. The bench provokes this with rounds that hold every ready at 100 %, that pace both sides at random, and that starve one side while the other runs freely. In every cycle, a behavioural model of occupancy, reservations and commitments predicts both command valids, the command fields, beat validity and the beat data, and each prediction is compared with the outputs.

// File: rtl/bsched_pkg.sv
package bsched_pkg;

    localparam int ADDR_W     = 32;
    localparam int CNT_W      = 16;
    localparam int DATA_W     = 128;
    localparam int BEAT_BYTES = DATA_W / 8;
    localparam int BEAT_SH    = $clog2(BEAT_BYTES);
    localparam int BADDR_W    = ADDR_W - BEAT_SH;
    localparam int BCNT_W     = CNT_W - BEAT_SH;

    typedef logic [BADDR_W-1:0] baddr_t;
    typedef logic [BCNT_W-1:0]  bcnt_t;

    // position of a context walk, counted in beats
    typedef struct packed {
        baddr_t addr;
        bcnt_t  left;
    } walk_t;

    // beats in the next command: stop at the burst-aligned edge or at the end
    function automatic bcnt_t split_len(input baddr_t a, input bcnt_t left,
                                        input int unsigned burst_beats);
        bcnt_t off;
        bcnt_t room;
        off  = bcnt_t'(a & baddr_t'(burst_beats - 1));
        room = bcnt_t'(burst_beats) - off;
        return (left < room) ? left : room;
    endfunction

    function automatic logic [ADDR_W-1:0] beat_to_byte(input baddr_t a);
        return {a, {BEAT_SH{1'b0}}};
    endfunction

endpackage

// File: rtl/bsched_fifo.sv
module bsched_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 128,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count
);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp;
    logic [PW-1:0] rp;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) wp <= bump(wp);
            if (pop)  rp <= bump(rp);
            count <= count + CW'(push) - CW'(pop);
        end
    end

    assign dout = mem[rp];

endmodule

// File: rtl/bsched_walk.sv
module bsched_walk
    import bsched_pkg::*;
#(
    parameter int BURST_BEATS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [CNT_W-1:0]  ld_bytes,
    input  logic              adv,
    output baddr_t            cur_addr,
    output bcnt_t             cur_left,
    output bcnt_t             cur_len
);

    walk_t w_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            w_q <= '0;
        end else if (ld) begin
            w_q.addr <= ld_addr[ADDR_W-1:BEAT_SH];
            w_q.left <= ld_bytes[CNT_W-1:BEAT_SH];
        end else if (adv) begin
            w_q.addr <= w_q.addr + baddr_t'(cur_len);
            w_q.left <= w_q.left - cur_len;
        end
    end

    assign cur_addr = w_q.addr;
    assign cur_left = w_q.left;
    assign cur_len  = split_len(w_q.addr, w_q.left, BURST_BEATS);

endmodule

// File: rtl/burst_sched.sv
module burst_sched
    import bsched_pkg::*;
#(
    parameter int FIFO_BEATS  = 16,
    parameter int BURST_BYTES = 128,
    localparam int BURST_BEATS = BURST_BYTES / BEAT_BYTES,
    localparam int LEN_W       = $clog2(BURST_BYTES + 1),
    localparam int CW          = $clog2(FIFO_BEATS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              src_valid,
    output logic              src_ready,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [CNT_W-1:0]  src_bytes,
    output logic              src_done,
    input  logic              dst_valid,
    output logic              dst_ready,
    input  logic [ADDR_W-1:0] dst_addr,
    input  logic [CNT_W-1:0]  dst_bytes,
    output logic              dst_done,
    output logic              rd_cmd_valid,
    input  logic              rd_cmd_ready,
    output logic [ADDR_W-1:0] rd_cmd_addr,
    output logic [LEN_W-1:0]  rd_cmd_bytes,
    input  logic              rd_ret_valid,
    input  logic [DATA_W-1:0] rd_ret_data,
    output logic              wr_cmd_valid,
    input  logic              wr_cmd_ready,
    output logic [ADDR_W-1:0] wr_cmd_addr,
    output logic [LEN_W-1:0]  wr_cmd_bytes,
    output logic              wr_beat_valid,
    input  logic              wr_beat_ready,
    output logic [DATA_W-1:0] wr_beat_data
);

    // shared channel storage
    logic [CW-1:0]     fifo_cnt;
    logic [DATA_W-1:0] fifo_dout;

    // source side state
    logic   s_act;
    logic   s_done_q;
    bcnt_t  s_ret;
    bcnt_t  s_left;
    bcnt_t  s_len;
    bcnt_t  s_outst;
    baddr_t s_addr;
    bcnt_t  src_beats;
    logic   src_fire;
    logic   rd_fits;
    logic   rd_fire;
    logic   ret_fire;

    // destination side state
    logic   d_act;
    logic   d_done_q;
    bcnt_t  d_pend;
    bcnt_t  d_left;
    bcnt_t  d_len;
    baddr_t d_addr;
    bcnt_t  dst_beats;
    logic   dst_fire;
    logic   wr_fits;
    logic   wr_fire;
    logic   pop;

    // ---------------- source side ----------------
    assign src_ready = ~s_act;
    assign src_fire  = src_valid & src_ready;
    assign src_beats = src_bytes[CNT_W-1:BEAT_SH];
    assign s_outst   = s_ret - s_left;
    assign rd_fits   = (32'(fifo_cnt) + 32'(s_outst) + 32'(s_len)) <= 32'(FIFO_BEATS);
    assign rd_cmd_valid = s_act & (s_left != '0) & rd_fits;
    assign rd_fire   = rd_cmd_valid & rd_cmd_ready;
    assign ret_fire  = rd_ret_valid & s_act;

    bsched_walk #(.BURST_BEATS(BURST_BEATS)) src_walk_i (
        .clk      (clk),
        .rst      (rst),
        .ld       (src_fire),
        .ld_addr  (src_addr),
        .ld_bytes (src_bytes),
        .adv      (rd_fire),
        .cur_addr (s_addr),
        .cur_left (s_left),
        .cur_len  (s_len)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s_act    <= 1'b0;
            s_ret    <= '0;
            s_done_q <= 1'b0;
        end else begin
            s_done_q <= 1'b0;
            if (src_fire) begin
                s_ret    <= src_beats;
                s_act    <= (src_beats != '0);
                s_done_q <= (src_beats == '0);
            end else if (ret_fire) begin
                s_ret <= s_ret - bcnt_t'(1);
                if (s_ret == bcnt_t'(1)) begin
                    s_act    <= 1'b0;
                    s_done_q <= 1'b1;
                end
            end
        end
    end

    assign src_done     = s_done_q;
    assign rd_cmd_addr  = beat_to_byte(s_addr);
    assign rd_cmd_bytes = LEN_W'(32'(s_len) << BEAT_SH);

    // ---------------- destination side ----------------
    assign dst_ready = ~d_act;
    assign dst_fire  = dst_valid & dst_ready;
    assign dst_beats = dst_bytes[CNT_W-1:BEAT_SH];
    assign wr_fits   = 32'(fifo_cnt) >= (32'(d_pend) + 32'(d_len));
    assign wr_cmd_valid  = d_act & (d_left != '0) & wr_fits;
    assign wr_fire       = wr_cmd_valid & wr_cmd_ready;
    assign wr_beat_valid = (d_pend != '0);
    assign pop           = wr_beat_valid & wr_beat_ready;

    bsched_walk #(.BURST_BEATS(BURST_BEATS)) dst_walk_i (
        .clk      (clk),
        .rst      (rst),
        .ld       (dst_fire),
        .ld_addr  (dst_addr),
        .ld_bytes (dst_bytes),
        .adv      (wr_fire),
        .cur_addr (d_addr),
        .cur_left (d_left),
        .cur_len  (d_len)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            d_act    <= 1'b0;
            d_pend   <= '0;
            d_done_q <= 1'b0;
        end else begin
            d_done_q <= 1'b0;
            if (dst_fire) begin
                d_act    <= (dst_beats != '0);
                d_pend   <= '0;
                d_done_q <= (dst_beats == '0);
            end else if (d_act) begin
                d_pend <= d_pend + (wr_fire ? d_len : bcnt_t'(0)) - bcnt_t'(pop);
                if (pop && d_pend == bcnt_t'(1) && d_left == '0) begin
                    d_act    <= 1'b0;
                    d_done_q <= 1'b1;
                end
            end
        end
    end

    assign dst_done     = d_done_q;
    assign wr_cmd_addr  = beat_to_byte(d_addr);
    assign wr_cmd_bytes = LEN_W'(32'(d_len) << BEAT_SH);

    // ---------------- channel FIFO ----------------
    bsched_fifo #(.DEPTH(FIFO_BEATS), .W(DATA_W)) fifo_i (
        .clk   (clk),
        .rst   (rst),
        .push  (ret_fire),
        .din   (rd_ret_data),
        .pop   (pop),
        .dout  (fifo_dout),
        .count (fifo_cnt)
    );

    assign wr_beat_data = fifo_dout;

endmodule

// File: rtl/burst_sched_chk.sv
module burst_sched_chk
    import bsched_pkg::*;
#(
    parameter int FIFO_BEATS  = 16,
    parameter int BURST_BYTES = 128,
    parameter int CW          = 5,
    parameter int LEN_W       = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_cmd_valid,
    input logic              rd_cmd_ready,
    input logic [ADDR_W-1:0] rd_cmd_addr,
    input logic [LEN_W-1:0]  rd_cmd_bytes,
    input logic              wr_cmd_valid,
    input logic              wr_cmd_ready,
    input logic [ADDR_W-1:0] wr_cmd_addr,
    input logic [LEN_W-1:0]  wr_cmd_bytes,
    input logic              wr_beat_valid,
    input logic              src_done,
    input logic              src_ready,
    input logic              dst_done,
    input logic              dst_ready,
    input logic [CW-1:0]     fifo_cnt,
    input bcnt_t             s_outst
);

    // R3: stored plus reserved beats never exceed the FIFO depth
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (32'(fifo_cnt) + 32'(s_outst)) <= 32'(FIFO_BEATS));

    // R5: a write beat is only offered with data present in the FIFO
    a_r5_beat_backed: assert property (@(posedge clk) disable iff (rst)
        wr_beat_valid |-> (fifo_cnt != '0));

    // R1: read commands are non-empty and stay inside one aligned burst
    a_r1_rd_in_burst: assert property (@(posedge clk) disable iff (rst)
        rd_cmd_valid |-> (rd_cmd_bytes != '0) &&
        ((32'(rd_cmd_addr) % 32'(BURST_BYTES)) + 32'(rd_cmd_bytes) <= 32'(BURST_BYTES)));

    // R2: write commands are non-empty and stay inside one aligned burst
    a_r2_wr_in_burst: assert property (@(posedge clk) disable iff (rst)
        wr_cmd_valid |-> (wr_cmd_bytes != '0) &&
        ((32'(wr_cmd_addr) % 32'(BURST_BYTES)) + 32'(wr_cmd_bytes) <= 32'(BURST_BYTES)));

    // R11: a stalled read command holds
    a_r11_rd_hold: assert property (@(posedge clk) disable iff (rst)
        (rd_cmd_valid && !rd_cmd_ready) |=>
        (rd_cmd_valid && $stable(rd_cmd_addr) && $stable(rd_cmd_bytes)));

    // R11: a stalled write command holds
    a_r11_wr_hold: assert property (@(posedge clk) disable iff (rst)
        (wr_cmd_valid && !wr_cmd_ready) |=>
        (wr_cmd_valid && $stable(wr_cmd_addr) && $stable(wr_cmd_bytes)));

    // R6: the source side is idle whenever it signals completion
    a_r6_src_done_idle: assert property (@(posedge clk) disable iff (rst)
        src_done |-> src_ready);

    // R7: the destination side is idle whenever it signals completion
    a_r7_dst_done_idle: assert property (@(posedge clk) disable iff (rst)
        dst_done |-> dst_ready);

endmodule

bind burst_sched burst_sched_chk #(
    .FIFO_BEATS  (FIFO_BEATS),
    .BURST_BYTES (BURST_BYTES),
    .CW          (CW),
    .LEN_W       (LEN_W)
) chk_i (
    .clk           (clk),
    .rst           (rst),
    .rd_cmd_valid  (rd_cmd_valid),
    .rd_cmd_ready  (rd_cmd_ready),
    .rd_cmd_addr   (rd_cmd_addr),
    .rd_cmd_bytes  (rd_cmd_bytes),
    .wr_cmd_valid  (wr_cmd_valid),
    .wr_cmd_ready  (wr_cmd_ready),
    .wr_cmd_addr   (wr_cmd_addr),
    .wr_cmd_bytes  (wr_cmd_bytes),
    .wr_beat_valid (wr_beat_valid),
    .src_done      (src_done),
    .src_ready     (src_ready),
    .dst_done      (dst_done),
    .dst_ready     (dst_ready),
    .fifo_cnt      (fifo_cnt),
    .s_outst       (s_outst)
);

// File: tb/burst_sched_tb_top.sv
`timescale 1ns/1ps
module burst_sched_tb_top;

    localparam int DEPTH = 16;
    localparam int NJ    = 7;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         src_valid = 1'b0;
    logic         src_ready;
    logic [31:0]  src_addr = '0;
    logic [15:0]  src_bytes = '0;
    logic         src_done;
    logic         dst_valid = 1'b0;
    logic         dst_ready;
    logic [31:0]  dst_addr = '0;
    logic [15:0]  dst_bytes = '0;
    logic         dst_done;
    logic         rd_cmd_valid;
    logic         rd_cmd_ready = 1'b0;
    logic [31:0]  rd_cmd_addr;
    logic [7:0]   rd_cmd_bytes;
    logic         rd_ret_valid = 1'b0;
    logic [127:0] rd_ret_data = '0;
    logic         wr_cmd_valid;
    logic         wr_cmd_ready = 1'b0;
    logic [31:0]  wr_cmd_addr;
    logic [7:0]   wr_cmd_bytes;
    logic         wr_beat_valid;
    logic         wr_beat_ready = 1'b0;
    logic [127:0] wr_beat_data;

    always #2.5 clk = ~clk;

    burst_sched dut_i (
        .clk(clk), .rst(rst),
        .src_valid(src_valid), .src_ready(src_ready), .src_addr(src_addr),
        .src_bytes(src_bytes), .src_done(src_done),
        .dst_valid(dst_valid), .dst_ready(dst_ready), .dst_addr(dst_addr),
        .dst_bytes(dst_bytes), .dst_done(dst_done),
        .rd_cmd_valid(rd_cmd_valid), .rd_cmd_ready(rd_cmd_ready),
        .rd_cmd_addr(rd_cmd_addr), .rd_cmd_bytes(rd_cmd_bytes),
        .rd_ret_valid(rd_ret_valid), .rd_ret_data(rd_ret_data),
        .wr_cmd_valid(wr_cmd_valid), .wr_cmd_ready(wr_cmd_ready),
        .wr_cmd_addr(wr_cmd_addr), .wr_cmd_bytes(wr_cmd_bytes),
        .wr_beat_valid(wr_beat_valid), .wr_beat_ready(wr_beat_ready),
        .wr_beat_data(wr_beat_data)
    );

    int n_vec = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int nlen(input int a, input int left);
        int room;
        room = 8 - (a % 8);
        return (left < room) ? left : room;
    endfunction

    // job table
    int sa [NJ] = '{'h1030, 'h2007, 'h3000, 'h4000, 'h5070, 'h6080, 'h7010};
    int sb [NJ] = '{400,    'h4F,   0,      1024,   16,     128,    480};
    int da [NJ] = '{'h9050, 'hA00C, 'hB000, 'hC040, 'hD0F0, 'hE000, 'hF070};
    int db [NJ] = '{400,    'h4F,   0,      1024,   16,     128,    480};

    // reference model state
    int m_sact = 0, m_saddr = 0, m_sleft = 0, m_sret = 0;
    int m_dact = 0, m_daddr = 0, m_dleft = 0, m_dpend = 0;
    int m_occ = 0, m_outst = 0, ret_pend = 0;
    int exp_sdone = 0, exp_ddone = 0, zero_s = 0, zero_d = 0;
    int overlap = 0;
    int dcnt = 1;
    logic [127:0] dq [$];

    int p_sv, p_dv, p_rc, p_rr, p_wc, p_wb;

    function automatic bit roll(input int pct);
        return ($urandom_range(0, 99) < pct);
    endfunction

    task automatic set_round(input int r);
        case (r)
            0: begin p_sv = 100; p_dv = 100; p_rc = 100; p_rr = 100; p_wc = 100; p_wb = 100; end
            1: begin p_sv = 50;  p_dv = 40;  p_rc = 50;  p_rr = 50;  p_wc = 50;  p_wb = 50;  end
            2: begin p_sv = 100; p_dv = 100; p_rc = 100; p_rr = 100; p_wc = 10;  p_wb = 8;   end
            default: begin p_sv = 100; p_dv = 100; p_rc = 12; p_rr = 15; p_wc = 100; p_wb = 100; end
        endcase
    endtask

    initial begin
        int sj, dj, round, cyc;
        int slen, dlen, beats;
        bit exp_rv, exp_wv, sfire, dfire, rfire, retf, wfire, bfire;
        bit new_sd, new_dd;
        sj = 0; dj = 0; round = 0; cyc = 0;
        set_round(0);
        void'($urandom(17));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12: state after reset
        chk(rd_cmd_valid == 1'b0, "R12 rd_cmd_valid", 128'(rd_cmd_valid), 0);
        chk(wr_cmd_valid == 1'b0, "R12 wr_cmd_valid", 128'(wr_cmd_valid), 0);
        chk(wr_beat_valid == 1'b0, "R12 wr_beat_valid", 128'(wr_beat_valid), 0);
        chk(src_ready && dst_ready, "R12 ready", 128'({src_ready, dst_ready}), 3);
        chk(!src_done && !dst_done, "R12 done", 128'({src_done, dst_done}), 0);

        forever begin
            cyc++;
            if (cyc > 150000) begin
                chk(1'b0, "watchdog expired", 128'(cyc), 0);
                break;
            end

            // ---- compare outputs against the model ----
            slen   = nlen(m_saddr, m_sleft);
            dlen   = nlen(m_daddr, m_dleft);
            exp_rv = (m_sact != 0) && (m_sleft > 0) && (DEPTH - m_occ - m_outst >= slen);
            exp_wv = (m_dact != 0) && (m_dleft > 0) && (m_occ - m_dpend >= dlen);

            chk(src_ready == (m_sact == 0), "R6 src_ready", 128'(src_ready), 128'(m_sact == 0));
            chk(dst_ready == (m_dact == 0), "R7 dst_ready", 128'(dst_ready), 128'(m_dact == 0));
            chk(rd_cmd_valid == exp_rv, "R3 rd_cmd_valid", 128'(rd_cmd_valid), 128'(exp_rv));
            if (exp_rv && rd_cmd_valid) begin
                chk(rd_cmd_addr == 32'(m_saddr * 16), "R1 rd addr", 128'(rd_cmd_addr), 128'(m_saddr * 16));
                chk(rd_cmd_bytes == 8'(slen * 16), "R1 rd len", 128'(rd_cmd_bytes), 128'(slen * 16));
                chk(rd_cmd_addr[3:0] == 4'h0, "R10 rd align", 128'(rd_cmd_addr), 0);
            end
            chk(wr_cmd_valid == exp_wv, "R4 wr_cmd_valid", 128'(wr_cmd_valid), 128'(exp_wv));
            if (exp_wv && wr_cmd_valid) begin
                chk(wr_cmd_addr == 32'(m_daddr * 16), "R2 wr addr", 128'(wr_cmd_addr), 128'(m_daddr * 16));
                chk(wr_cmd_bytes == 8'(dlen * 16), "R2 wr len", 128'(wr_cmd_bytes), 128'(dlen * 16));
                chk(wr_cmd_addr[3:0] == 4'h0, "R10 wr align", 128'(wr_cmd_addr), 0);
            end
            chk(wr_beat_valid == (m_dpend > 0), "R5 wr_beat_valid", 128'(wr_beat_valid), 128'(m_dpend > 0));
            if (wr_beat_valid && m_dpend > 0 && dq.size() > 0)
                chk(wr_beat_data == dq[0], "R5 beat data", wr_beat_data, dq[0]);
            chk(src_done == (exp_sdone != 0), "R6 src_done", 128'(src_done), 128'(exp_sdone));
            chk(dst_done == (exp_ddone != 0), "R7 dst_done", 128'(dst_done), 128'(exp_ddone));
            if (zero_s != 0) begin
                chk(src_done == 1'b1, "R9 src zero done", 128'(src_done), 1);
                chk(rd_cmd_valid == 1'b0, "R9 src zero no cmd", 128'(rd_cmd_valid), 0);
            end
            if (zero_d != 0) begin
                chk(dst_done == 1'b1, "R9 dst zero done", 128'(dst_done), 1);
                chk(wr_cmd_valid == 1'b0, "R9 dst zero no cmd", 128'(wr_cmd_valid), 0);
            end
            zero_s = 0; zero_d = 0;

            // ---- round control ----
            if (sj == NJ && dj == NJ && m_sact == 0 && m_dact == 0 &&
                exp_sdone == 0 && exp_ddone == 0) begin
                round++;
                if (round == 4) break;
                set_round(round);
                sj = 0; dj = 0;
            end

            // ---- drive inputs ----
            src_valid = (sj < NJ) && roll(p_sv);
            src_addr  = (sj < NJ) ? 32'(sa[sj]) : '0;
            src_bytes = (sj < NJ) ? 16'(sb[sj]) : '0;
            dst_valid = (dj < NJ) && roll(p_dv);
            dst_addr  = (dj < NJ) ? 32'(da[dj]) : '0;
            dst_bytes = (dj < NJ) ? 16'(db[dj]) : '0;
            rd_cmd_ready  = roll(p_rc);
            rd_ret_valid  = (ret_pend > 0) && roll(p_rr);
            rd_ret_data   = rd_ret_valid ? {4{32'(dcnt)}} : '0;
            wr_cmd_ready  = roll(p_wc);
            wr_beat_ready = roll(p_wb);

            // ---- advance the model by one clock ----
            sfire = src_valid && (m_sact == 0);
            dfire = dst_valid && (m_dact == 0);
            rfire = exp_rv && rd_cmd_ready;
            retf  = rd_ret_valid;
            wfire = exp_wv && wr_cmd_ready;
            bfire = (m_dpend > 0) && wr_beat_ready;
            new_sd = 0; new_dd = 0;

            if (bfire) begin
                void'(dq.pop_front());
                m_occ--;
            end
            if (m_dact != 0) begin
                if (wfire) begin
                    m_daddr += dlen; m_dleft -= dlen; m_dpend += dlen;
                end
                if (bfire) begin
                    m_dpend--;
                    if (m_dpend == 0 && m_dleft == 0) begin
                        m_dact = 0; new_dd = 1;
                    end
                end
            end
            if (retf) begin
                dq.push_back({4{32'(dcnt)}});
                dcnt++;
                m_occ++; m_outst--; ret_pend--; m_sret--;
                if (m_sret == 0) begin
                    m_sact = 0; new_sd = 1;
                end
            end
            if (rfire) begin
                m_saddr += slen; m_sleft -= slen; m_outst += slen; ret_pend += slen;
            end
            if (sfire) begin
                beats = sb[sj] / 16;
                if (m_dact != 0) overlap++;
                if (beats == 0) begin
                    new_sd = 1; zero_s = 1;
                end else begin
                    m_sact = 1; m_saddr = sa[sj] / 16; m_sleft = beats; m_sret = beats;
                end
                sj++;
            end
            if (dfire) begin
                beats = db[dj] / 16;
                if (beats == 0) begin
                    new_dd = 1; zero_d = 1;
                end else begin
                    m_dact = 1; m_daddr = da[dj] / 16; m_dleft = beats; m_dpend = 0;
                end
                dj++;
            end
            exp_sdone = new_sd;
            exp_ddone = new_dd;

            @(negedge clk);
        end

        // R8: source side took a new context while the destination was busy
        chk(overlap > 0, "R8 overlap", 128'(overlap), 1);
        chk(dq.size() == 0, "R5 all data written", 128'(dq.size()), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule